// File: doc/BRIEF.md
# Split-Tenure Bus Arbiter

This block shares one processor bus among three masters. The bus carries an address tenure and a data tenure for each transaction. The arbiter grants these two tenures separately. An address grant goes to one requesting master, chosen in round-robin order, and stays asserted until the bus signals that the address was accepted. Each accepted address tenure joins an ordered queue of pending data tenures. The queue holds at most two entries. The data bus is then offered to the oldest pending tenure as a single-cycle grant pulse.

A retry seen in the cycle right after an address acceptance cancels that tenure before any data grant is issued for it. A data grant counts only when the data bus is idle during the pulse cycle. If the bus is busy in that cycle, the grant is wasted and the same tenure is offered again later. Masters may drop their requests at any time without affecting tenures that are already queued. All grants are registered.

Top module: `tenure_arbiter`

## Requirements
- R1: A synchronous active-high reset negates every address and data grant (all grant pins high) and empties the data queue. After reset, no data grant appears until a new address tenure has been accepted.
- R2: Address grants (`abg_n`) are active low and at most one is asserted at a time. A grant stays asserted until `aack_n` is sampled low while it is asserted, and it is negated in the following cycle. `aack_n` is ignored while no address grant is asserted.
- R3: A new address grant goes to the first requesting master (`req_n` bit low) after the most recently granted master, in increasing index order with wrap-around. After reset, master 0 has first priority.
- R4: No new address grant is issued while two data tenures are outstanding. A tenure counts as outstanding from its acceptance until it is retired or cancelled.
- R5: Each accepted address tenure is queued with its master's index. Data grants (`dbg_n`, active low) follow acceptance order, and only the queue head is granted.
- R6: A data grant is a single-cycle pulse on at most one master. It is always followed by at least one cycle with all data grants negated.
- R7: A data grant is asserted only if `dbusy_n` was high in the previous cycle. A tenure becomes eligible for a data grant no earlier than the second cycle after its acceptance, so the earliest pulse comes three cycles after the `aack_n` cycle.
- R8: If `retry_n` is low in the cycle right after an acceptance, that tenure is removed from the queue and never receives a data grant. A retry in any other cycle leaves the queue unchanged.
- R9: A data grant is qualified, and retires the queue head, only when `dbusy_n` is high during the pulse cycle. Otherwise the head stays queued and is granted again later.
- R10: Queued tenures are kept and granted whether or not any master is still requesting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| req_n | input | 3 | Per-master bus request, active low |
| aack_n | input | 1 | Address tenure accepted, active low |
| retry_n | input | 1 | Address retry, active low |
| dbusy_n | input | 1 | Data bus busy, active low |
| abg_n | output | 3 | Per-master address grant, active low |
| dbg_n | output | 3 | Per-master one-cycle data grant, active low |

## Verification
Two kinds of same-cycle collision are driven. In the first, the queue head is retired by a qualified data grant in the same cycle that a retry cancels the newest tenure. In the second, a new acceptance is pushed into the queue in the same cycle that the head is popped. Both are provoked by holding the queue full while the bus is busy, then releasing the busy line while retries are aimed at the cycle after each acceptance. A random phase repeats these patterns many times. An in-order reference queue in the bench predicts both grant vectors every cycle, so a lost, duplicated or reordered tenure appears as a grant mismatch.

// File: rtl/tarb_pkg.sv
package tarb_pkg;

  // circular pointer step helpers
  function automatic int wrap_inc(int v, int n);
    return (v == n - 1) ? 0 : v + 1;
  endfunction

  function automatic int wrap_dec(int v, int n);
    return (v == 0) ? n - 1 : v - 1;
  endfunction

endpackage

// File: rtl/tarb_addr_arb.sv
module tarb_addr_arb #(
  parameter int NUM_M  = 3,
  parameter int QDEPTH = 2,
  parameter int IW     = 2,
  parameter int CW     = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NUM_M-1:0] req_n,
  input  logic             aack_n,
  input  logic [CW-1:0]    q_cnt,
  output logic [NUM_M-1:0] abg_n,
  output logic             push,
  output logic [IW-1:0]    push_id
);

  logic          gnt_vld;
  logic [IW-1:0] gnt_id;
  logic [IW-1:0] last_id;
  logic          found;
  logic [IW-1:0] pick;
  logic          room;

  // round-robin search starting after the last granted master
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int off = 1; off <= NUM_M; off++) begin
      int idx;
      idx = (int'(last_id) + off) % NUM_M;
      if (!found && !req_n[idx]) begin
        found = 1'b1;
        pick  = IW'(idx);
      end
    end
  end

  assign room    = (q_cnt < CW'(QDEPTH));
  assign push    = gnt_vld && !aack_n;
  assign push_id = gnt_id;

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_vld <= 1'b0;
      gnt_id  <= '0;
      last_id <= IW'(NUM_M - 1);
      abg_n   <= {NUM_M{1'b1}};
    end else if (gnt_vld) begin
      if (push) begin
        gnt_vld <= 1'b0;
        abg_n   <= {NUM_M{1'b1}};
      end
    end else if (found && room) begin
      gnt_vld <= 1'b1;
      gnt_id  <= pick;
      last_id <= pick;
      abg_n   <= ~(NUM_M'(1) << pick);
    end
  end

  AST_ABG_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~abg_n)); // R2

  AST_ABG_HOLD: assert property (@(posedge clk) disable iff (rst)
    ((abg_n != {NUM_M{1'b1}}) && aack_n) |=> $stable(abg_n)); // R2

  AST_ABG_RELEASE: assert property (@(posedge clk) disable iff (rst)
    ((abg_n != {NUM_M{1'b1}}) && !aack_n) |=> (abg_n == {NUM_M{1'b1}})); // R2

  AST_ABG_WITHHELD: assert property (@(posedge clk) disable iff (rst)
    ((abg_n == {NUM_M{1'b1}}) && (q_cnt >= CW'(QDEPTH))) |=> (abg_n == {NUM_M{1'b1}})); // R4

endmodule

// File: rtl/tarb_data_queue.sv
module tarb_data_queue #(
  parameter int QDEPTH = 2,
  parameter int IW     = 2,
  parameter int CW     = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [IW-1:0] push_id,
  input  logic          retry_n,
  input  logic          pop,
  output logic [IW-1:0] head_id,
  output logic          head_ok,
  output logic [CW-1:0] cnt,
  output logic          cancel
);

  localparam int PW = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;

  logic [IW-1:0] mem [QDEPTH];
  logic [PW-1:0] wr_ptr;
  logic [PW-1:0] rd_ptr;
  logic          fresh;

  // the newest entry sits in its retry window for one cycle
  assign cancel  = fresh && !retry_n;
  assign head_id = mem[rd_ptr];
  assign head_ok = (cnt != '0) && !(fresh && (cnt == CW'(1)));

  // storage without reset so it can map onto memory
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_id;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
      fresh  <= 1'b0;
    end else begin
      fresh <= push;
      if (push)
        wr_ptr <= PW'(tarb_pkg::wrap_inc(int'(wr_ptr), QDEPTH));
      else if (cancel)
        wr_ptr <= PW'(tarb_pkg::wrap_dec(int'(wr_ptr), QDEPTH));
      if (pop)
        rd_ptr <= PW'(tarb_pkg::wrap_inc(int'(rd_ptr), QDEPTH));
      cnt <= cnt + CW'(push) - CW'(cancel) - CW'(pop);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    push |-> (cnt < CW'(QDEPTH))); // R4

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    (pop || cancel) |-> (cnt != '0)); // R9

  AST_CANCEL_DROPS: assert property (@(posedge clk) disable iff (rst)
    (cancel && !pop) |=> (cnt == $past(cnt) - CW'(1))); // R8

endmodule

// File: rtl/tarb_dgrant.sv
module tarb_dgrant #(
  parameter int NUM_M = 3,
  parameter int IW    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             head_ok,
  input  logic [IW-1:0]    head_id,
  input  logic             dbusy_n,
  output logic [NUM_M-1:0] dbg_n,
  output logic             pop,
  output logic [IW-1:0]    pulse_id
);

  logic pulse_vld;
  logic issue;

  assign issue = head_ok && dbusy_n && !pulse_vld;
  // qualified grant: bus idle during the pulse cycle
  assign pop   = pulse_vld && dbusy_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_vld <= 1'b0;
      pulse_id  <= '0;
      dbg_n     <= {NUM_M{1'b1}};
    end else begin
      pulse_vld <= issue;
      pulse_id  <= head_id;
      dbg_n     <= issue ? ~(NUM_M'(1) << head_id) : {NUM_M{1'b1}};
    end
  end

  AST_DBG_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~dbg_n)); // R6

  AST_DBG_PULSE: assert property (@(posedge clk) disable iff (rst)
    (dbg_n != {NUM_M{1'b1}}) |=> (dbg_n == {NUM_M{1'b1}})); // R6

  AST_DBG_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    $fell(dbg_n != {NUM_M{1'b1}} ? 1'b0 : 1'b1) |-> $past(dbusy_n)); // R7

endmodule

// File: rtl/tenure_arbiter.sv
module tenure_arbiter #(
  parameter int NUM_M  = 3,
  parameter int QDEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NUM_M-1:0] req_n,
  input  logic             aack_n,
  input  logic             retry_n,
  input  logic             dbusy_n,
  output logic [NUM_M-1:0] abg_n,
  output logic [NUM_M-1:0] dbg_n
);

  localparam int IW = (NUM_M > 1) ? $clog2(NUM_M) : 1;
  localparam int CW = $clog2(QDEPTH + 1);

  logic          push;
  logic [IW-1:0] push_id;
  logic [IW-1:0] head_id;
  logic          head_ok;
  logic [CW-1:0] q_cnt;
  logic          cancel;
  logic          pop;
  logic [IW-1:0] pulse_id;

  tarb_addr_arb #(.NUM_M(NUM_M), .QDEPTH(QDEPTH), .IW(IW), .CW(CW)) u_addr (
    .clk(clk), .rst(rst), .req_n(req_n), .aack_n(aack_n), .q_cnt(q_cnt),
    .abg_n(abg_n), .push(push), .push_id(push_id)
  );

  tarb_data_queue #(.QDEPTH(QDEPTH), .IW(IW), .CW(CW)) u_queue (
    .clk(clk), .rst(rst), .push(push), .push_id(push_id), .retry_n(retry_n),
    .pop(pop), .head_id(head_id), .head_ok(head_ok), .cnt(q_cnt), .cancel(cancel)
  );

  tarb_dgrant #(.NUM_M(NUM_M), .IW(IW)) u_dgnt (
    .clk(clk), .rst(rst), .head_ok(head_ok), .head_id(head_id), .dbusy_n(dbusy_n),
    .dbg_n(dbg_n), .pop(pop), .pulse_id(pulse_id)
  );

  AST_POP_IS_HEAD: assert property (@(posedge clk) disable iff (rst)
    pop |-> (head_id == pulse_id)); // R5

  AST_CANCEL_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    cancel |-> $past(push)); // R8

  AST_FRESH_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
    (push && (q_cnt == '0)) |=> (dbg_n == {NUM_M{1'b1}})); // R7

endmodule

// File: tb/sim_tenure_arbiter.sv
`timescale 1ns/1ps
module sim_tenure_arbiter;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] req_n = 3'b111;
  logic       aack_n = 1'b1;
  logic       retry_n = 1'b1;
  logic       dbusy_n = 1'b1;
  logic [2:0] abg_n;
  logic [2:0] dbg_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tenure_arbiter u0 (
    .clk(clk), .rst(rst), .req_n(req_n), .aack_n(aack_n), .retry_n(retry_n),
    .dbusy_n(dbusy_n), .abg_n(abg_n), .dbg_n(dbg_n)
  );

  // reference model state
  bit         m_gv, m_fresh, m_pv;
  int         m_gid, m_last, m_pid, mqn;
  int         mq [2];
  logic [2:0] exp_abg = 3'b111;
  logic [2:0] exp_dbg = 3'b111;
  string      tag_a = "R1";
  string      tag_d = "R1";
  bit         prev_busy_ok = 1;
  bit         prev_dbg_any = 0;
  int         pulses = 0;

  task automatic chk(bit ok, string tag, logic [2:0] act, logic [2:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%b exp=%b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int rr_pick(logic [2:0] rq, int last);
    for (int off = 1; off <= 3; off++) begin
      int idx;
      idx = (last + off) % 3;
      if (!rq[idx]) return idx;
    end
    return -1;
  endfunction

  task automatic model_reset();
    m_gv = 0; m_fresh = 0; m_pv = 0; m_gid = 0; m_last = 2; m_pid = 0; mqn = 0;
    exp_abg = 3'b111; exp_dbg = 3'b111; tag_a = "R1"; tag_d = "R1";
  endtask

  task automatic model_step();
    bit pop, push, cancel, elig, issue;
    int nid, pk;
    if (rst) begin model_reset(); return; end
    pop    = m_pv && dbusy_n;
    push   = m_gv && !aack_n;
    cancel = m_fresh && !retry_n;
    elig   = (mqn > 0) && !(m_fresh && mqn == 1);
    issue  = elig && dbusy_n && !m_pv;
    nid    = mq[0];
    tag_d  = cancel ? "R8" : ((m_pv && !dbusy_n) ? "R9" : (issue ? "R7" : "R5"));
    tag_a  = m_gv ? "R2" : "R3";
    if (!m_gv) begin
      pk = rr_pick(req_n, m_last);
      if (pk >= 0 && mqn < 2) begin m_gv = 1; m_gid = pk; m_last = pk; end
      else if (pk >= 0) tag_a = "R4";
    end else if (push) m_gv = 0;
    if (pop) begin mq[0] = mq[1]; mqn--; end
    if (cancel) mqn--;
    if (push) begin mq[mqn] = (m_gv ? m_gid : m_gid); mqn++; end
    m_fresh = push;
    m_pv = issue; m_pid = nid;
    exp_abg = m_gv ? ~(3'b001 << m_gid) : 3'b111;
    exp_dbg = m_pv ? ~(3'b001 << m_pid) : 3'b111;
  endtask

  // one bus cycle: check outputs, drive new inputs, advance the model
  task automatic cyc(int p_req, int p_ack, int p_retry, int p_busy);
    @(negedge clk);
    chk(abg_n === exp_abg, tag_a, abg_n, exp_abg);
    chk(dbg_n === exp_dbg, tag_d, dbg_n, exp_dbg);
    if (dbg_n != 3'b111) begin
      pulses++;
      chk(prev_busy_ok, "R7", dbg_n, 3'b111);
    end
    if (prev_dbg_any) chk(dbg_n == 3'b111, "R6", dbg_n, 3'b111);
    prev_dbg_any = (dbg_n != 3'b111) && !rst;
    for (int i = 0; i < 3; i++) req_n[i] = !($urandom_range(99, 0) < p_req);
    aack_n  = m_gv ? !($urandom_range(99, 0) < p_ack) : !($urandom_range(99, 0) < 3);
    retry_n = m_fresh ? !($urandom_range(99, 0) < p_retry) : !($urandom_range(99, 0) < 3);
    dbusy_n = !($urandom_range(99, 0) < p_busy);
    prev_busy_ok = dbusy_n;
    model_step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    model_reset();
    // R1: reset state
    repeat (3) cyc(100, 0, 0, 0);
    @(negedge clk);
    chk(abg_n == 3'b111, "R1", abg_n, 3'b111);
    chk(dbg_n == 3'b111, "R1", dbg_n, 3'b111);
    rst = 1'b0;
    model_step();
    // R3: master 0 first after reset when all request
    req_n = 3'b000; aack_n = 1'b1; retry_n = 1'b1; dbusy_n = 1'b1;
    model_step();
    @(negedge clk);
    chk(abg_n == 3'b110, "R3", abg_n, 3'b110);
    // R4: fill the queue while the bus is busy
    repeat (20) cyc(100, 100, 0, 100);
    @(negedge clk);
    chk(abg_n == 3'b111, "R4", abg_n, 3'b111);
    chk(mqn == 2, "R4", 3'(mqn), 3'd2);
    model_step();
    // R10: drain with no requests
    pulses = 0;
    repeat (20) cyc(0, 100, 0, 0);
    chk(pulses == 2, "R10", 3'(pulses), 3'd2);
    // R8: every tenure retried, never granted
    pulses = 0;
    repeat (40) cyc(100, 100, 100, 0);
    chk(pulses == 0, "R8", 3'(pulses), 3'd0);
    // R1: reset with a full queue, then no data grant
    repeat (20) cyc(100, 100, 0, 100);
    rst = 1'b1;
    repeat (2) cyc(0, 0, 0, 0);
    rst = 1'b0;
    model_reset();
    pulses = 0;
    repeat (15) cyc(0, 0, 0, 0);
    chk(pulses == 0, "R1", 3'(pulses), 3'd0);
    // R9: busy during pulses, mixed traffic
    repeat (400) cyc(80, 60, 30, 50);
    // collision provoking and random phases
    for (int k = 0; k < 40; k++) begin
      repeat (12) cyc(100, 100, 0, 100);
      repeat (12) cyc(70, 80, 50, 10);
    end
    repeat (4000) cyc($urandom_range(100, 0), $urandom_range(100, 20),
                      $urandom_range(60, 0), $urandom_range(70, 0));
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule